// File: doc/BRIEF.md
# Dual-Reference Switchover and Holdover Controller

This block watches two reference clock inputs and decides which one drives a downstream loop. It runs entirely on a free-running local clock. Each reference is brought into that domain through a synchronizer and edge detector. A per-reference monitor then tracks the gap since the last rising edge and a run of good edges.

A reference counts as present once it has produced a programmed number of consecutive rising edges, each arriving before a programmed timeout. It is declared lost when the timeout expires with no edge. The controller gives the active role to a present reference and keeps the other, when present, as backup. It fails over to the backup when the active reference is lost, and it enters holdover when nothing usable remains.

Roles are non-revertive. A recovered reference becomes the backup, and a one-cycle alignment request tells the phase-alignment logic to line it up with the active edge.

Top module: `dual_ref_selector`

## Requirements
- R1: A reference becomes present after `cfgGood` (at least 1) rising edges in a row, each seen within `cfgTimeout` local cycles of the previous one. It becomes absent once `cfgTimeout` local cycles pass with no rising edge, and the good-edge run restarts from zero.
- R2: Each reference passes through a two-flop synchronizer and a rising-edge detector clocked by the local clock. Take a reference that rises at a half-cycle before posedge 1, has period 6, and is checked with `cfgGood`=3 and `cfgTimeout`=12. Starting from holdover, `holdover` falls after posedge 16.
- R3: `backupValid` is 1 exactly when the block is not in holdover and the non-active reference is present; it is never 1 during holdover.
- R4: If only one reference is present, it becomes active (`activeSel` 0 = reference A, 1 = reference B) on the clock edge after its presence is detected.
- R5: When leaving holdover with both references present in the same cycle, reference A becomes active.
- R6: When the active reference is lost and the other is present, the other becomes active on the next edge. An active reference that stays present keeps its role even when the other reference recovers.
- R7: `alignReq` pulses high for exactly one cycle, on the same edge that `backupValid` goes from 0 to 1, and at no other time.
- R8: With neither reference present, `holdover` is 1 from the next edge. Holdover is left on the edge after any reference becomes present.
- R9: After reset, `holdover`=1, `activeSel`=0, `backupValid`=0 and `alignReq`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running local clock |
| rstN | input | 1 | Asynchronous active-low reset |
| refA | input | 1 | Reference clock A (asynchronous) |
| refB | input | 1 | Reference clock B (asynchronous) |
| cfgTimeout | input | CNT_W | Local cycles without a rising edge before a reference is lost |
| cfgGood | input | GOOD_W | Consecutive good edges needed for presence |
| activeSel | output | 1 | Active reference: 0 = A, 1 = B |
| backupValid | output | 1 | The non-active reference is present and held as backup |
| holdover | output | 1 | No reference usable |
| alignReq | output | 1 | One-cycle request to align the new backup to the active edge |

## Verification
The hardest situation to reach is both references becoming present in the very same local cycle while the block is in holdover. Only that case exercises the priority of reference A. The bench reaches it by stopping both references until both monitors time out, then starting both generators from one drive step with identical periods, so their edge runs complete together. A second hard point is a backup appearing while the active reference stays healthy. The bench produces it by restarting a failed reference and counting alignment pulses over the window.

// File: rtl/dual_ref_pkg.sv
package dual_ref_pkg;

  localparam int NUM_REFS = 2;

  // strobes issued by the control to the output registers
  typedef struct packed {
    logic selA;       // make reference A active, leave holdover
    logic selB;       // make reference B active, leave holdover
    logic goHold;     // enter holdover
    logic bkupOn;     // a backup is now established
    logic bkupOff;    // backup no longer present
    logic alignPulse; // request edge alignment of the new backup
  } ctlStrobe_t;

endpackage

// File: rtl/ref_monitor.sv
module ref_monitor #(
  parameter int CNT_W  = 16,
  parameter int GOOD_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refIn,
  input  logic [CNT_W-1:0]  cfgTimeout,
  input  logic [GOOD_W-1:0] cfgGood,
  output logic              refValid
);

  logic [2:0]        syncQ;
  logic              edgeSeen;
  logic              expired;
  logic [CNT_W-1:0]  gapCnt;
  logic [GOOD_W-1:0] goodCnt;

  // two synchronizing flops plus one history flop for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[1:0], refIn};
  end

  assign edgeSeen = syncQ[1] & ~syncQ[2];
  assign expired  = (gapCnt == cfgTimeout);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapCnt  <= '0;
      goodCnt <= '0;
    end else if (edgeSeen) begin
      gapCnt <= '0;
      if (expired)              goodCnt <= GOOD_W'(1);
      else if (goodCnt < cfgGood) goodCnt <= goodCnt + GOOD_W'(1);
    end else begin
      if (!expired) gapCnt <= gapCnt + CNT_W'(1);
      else          goodCnt <= '0;
    end
  end

  assign refValid = !expired && (goodCnt != '0) && (goodCnt >= cfgGood);

  // R1
  rise_after_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(refValid) |-> $past(edgeSeen));

endmodule

// File: rtl/dual_ref_datapath.sv
module dual_ref_datapath
  import dual_ref_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int GOOD_W = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_REFS-1:0] refVec,
  input  logic [CNT_W-1:0]    cfgTimeout,
  input  logic [GOOD_W-1:0]   cfgGood,
  input  ctlStrobe_t          strobe,
  output logic [NUM_REFS-1:0] refValid,
  output logic                activeSel,
  output logic                backupValid,
  output logic                holdover,
  output logic                alignReq
);

  for (genvar i = 0; i < NUM_REFS; i++) begin : g_mon
    ref_monitor #(.CNT_W(CNT_W), .GOOD_W(GOOD_W)) mon_i (
      .clk        (clk),
      .rstN       (rstN),
      .refIn      (refVec[i]),
      .cfgTimeout (cfgTimeout),
      .cfgGood    (cfgGood),
      .refValid   (refValid[i])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeSel   <= 1'b0;
      holdover    <= 1'b1;
      backupValid <= 1'b0;
      alignReq    <= 1'b0;
    end else begin
      if (strobe.selA) begin
        activeSel <= 1'b0;
        holdover  <= 1'b0;
      end else if (strobe.selB) begin
        activeSel <= 1'b1;
        holdover  <= 1'b0;
      end else if (strobe.goHold) begin
        holdover  <= 1'b1;
      end
      if (strobe.bkupOn)       backupValid <= 1'b1;
      else if (strobe.bkupOff) backupValid <= 1'b0;
      alignReq <= strobe.alignPulse;
    end
  end

  // R3
  hold_no_bkup_chk: assert property (@(posedge clk) disable iff (!rstN)
    holdover |-> !backupValid);

  // R7
  align_needs_bkup_chk: assert property (@(posedge clk) disable iff (!rstN)
    alignReq |-> (backupValid && !$past(backupValid)));

endmodule

// File: rtl/dual_ref_control.sv
module dual_ref_control
  import dual_ref_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_REFS-1:0] refValid,
  input  logic                selIn,
  input  logic                holdIn,
  input  logic                bkupIn,
  output ctlStrobe_t          strobe
);

  logic vA, vB;
  logic nextHold, nextSel, nextBkup;
  logic activeOk, otherOk;

  assign vA = refValid[0];
  assign vB = refValid[1];
  assign activeOk = selIn ? vB : vA;
  assign otherOk  = selIn ? vA : vB;

  always_comb begin
    nextHold = holdIn;
    nextSel  = selIn;
    if (holdIn) begin
      if (vA) begin
        nextHold = 1'b0;
        nextSel  = 1'b0;
      end else if (vB) begin
        nextHold = 1'b0;
        nextSel  = 1'b1;
      end
    end else if (!activeOk) begin
      if (otherOk) nextSel  = ~selIn;
      else         nextHold = 1'b1;
    end
    nextBkup = !nextHold && (nextSel ? vA : vB);
  end

  always_comb begin
    strobe            = '0;
    strobe.selA       = !nextHold && !nextSel && (holdIn || selIn);
    strobe.selB       = !nextHold && nextSel && (holdIn || !selIn);
    strobe.goHold     = nextHold && !holdIn;
    strobe.bkupOn     = nextBkup && !bkupIn;
    strobe.bkupOff    = !nextBkup && bkupIn;
    strobe.alignPulse = nextBkup && !bkupIn;
  end

  // R8
  neither_to_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!vA && !vB) |=> holdIn);

  // R5
  prio_a_chk: assert property (@(posedge clk) disable iff (!rstN)
    (holdIn && vA) |=> (!selIn && !holdIn));

  // R6
  failover_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!holdIn && !activeOk && otherOk) |=> (selIn != $past(selIn) && !holdIn));

  // R6
  no_revert_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!holdIn && activeOk) |=> ($stable(selIn) && !holdIn));

endmodule

// File: rtl/dual_ref_selector.sv
module dual_ref_selector
  import dual_ref_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int GOOD_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refA,
  input  logic              refB,
  input  logic [CNT_W-1:0]  cfgTimeout,
  input  logic [GOOD_W-1:0] cfgGood,
  output logic              activeSel,
  output logic              backupValid,
  output logic              holdover,
  output logic              alignReq
);

  ctlStrobe_t          strobe;
  logic [NUM_REFS-1:0] refValid;

  dual_ref_datapath #(.CNT_W(CNT_W), .GOOD_W(GOOD_W)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .refVec      ({refB, refA}),
    .cfgTimeout  (cfgTimeout),
    .cfgGood     (cfgGood),
    .strobe      (strobe),
    .refValid    (refValid),
    .activeSel   (activeSel),
    .backupValid (backupValid),
    .holdover    (holdover),
    .alignReq    (alignReq)
  );

  dual_ref_control ctl_i (
    .clk      (clk),
    .rstN     (rstN),
    .refValid (refValid),
    .selIn    (activeSel),
    .holdIn   (holdover),
    .bkupIn   (backupValid),
    .strobe   (strobe)
  );

endmodule

// File: tb/dual_ref_selector_tb_top.sv
module dual_ref_selector_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;
  localparam int GOOD_W = 4;
  localparam int TMO = 12;
  localparam int GOOD = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refA = 1'b0, refB = 1'b0;
  logic activeSel, backupValid, holdover, alignReq;

  int total = 0, bad = 0;
  bit finished = 0;

  // generator state
  bit enA = 0, enB = 0;
  int halfA = 3, halfB = 3, cntA = 0, cntB = 0;
  int alignCount = 0;

  // reference model state
  int mS1[2], mS2[2], mS3[2], mGap[2], mGood[2];
  bit mHold = 1, mSel = 0, mBkup = 0, mAlign = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_ref_selector #(.CNT_W(CNT_W), .GOOD_W(GOOD_W)) dut_i (
    .clk(clk), .rstN(rstN), .refA(refA), .refB(refB),
    .cfgTimeout(CNT_W'(TMO)), .cfgGood(GOOD_W'(GOOD)),
    .activeSel(activeSel), .backupValid(backupValid),
    .holdover(holdover), .alignReq(alignReq)
  );

  // behavioural model, one step per rising clock edge
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 2; i++) begin
        mS1[i] = 0; mS2[i] = 0; mS3[i] = 0; mGap[i] = 0; mGood[i] = 0;
      end
      mHold = 1; mSel = 0; mBkup = 0; mAlign = 0;
    end else begin
      bit v[2];
      bit nh, ns, nb;
      int inp[2];
      for (int i = 0; i < 2; i++)
        v[i] = (mGap[i] != TMO) && (mGood[i] >= GOOD) && (mGood[i] != 0);
      nh = mHold; ns = mSel;
      if (mHold) begin
        if (v[0]) begin nh = 0; ns = 0; end
        else if (v[1]) begin nh = 0; ns = 1; end
      end else if (!v[mSel]) begin
        if (v[!mSel]) ns = !mSel;
        else nh = 1;
      end
      nb = !nh && v[!ns];
      mAlign = nb && !mBkup;
      mHold = nh; mSel = ns; mBkup = nb;
      inp[0] = refA; inp[1] = refB;
      for (int i = 0; i < 2; i++) begin
        bit e, x;
        e = mS2[i] && !mS3[i];
        x = (mGap[i] == TMO);
        if (e) begin
          mGood[i] = x ? 1 : (mGood[i] < GOOD ? mGood[i] + 1 : mGood[i]);
          mGap[i] = 0;
        end else if (!x) mGap[i]++;
        else mGood[i] = 0;
        mS3[i] = mS2[i]; mS2[i] = mS1[i]; mS1[i] = inp[i];
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  // one local cycle: compare against the model, then drive the references
  task automatic tick();
    @(negedge clk);
    if (rstN) begin
      chk("R6 activeSel", activeSel, mSel);
      chk("R8 holdover", holdover, mHold);
      chk("R3 backupValid", backupValid, mBkup);
      chk("R7 alignReq", alignReq, mAlign);
    end
    if (alignReq) alignCount++;
    if (!enA) begin refA = 0; cntA = 0; end
    else begin
      if (cntA == 0) refA = 1;
      if (cntA == halfA) refA = 0;
      cntA = (cntA == 2*halfA-1) ? 0 : cntA + 1;
    end
    if (!enB) begin refB = 0; cntB = 0; end
    else begin
      if (cntB == 0) refB = 1;
      if (cntB == halfB) refB = 0;
      cntB = (cntB == 2*halfB-1) ? 0 : cntB + 1;
    end
  endtask

  task automatic run(input int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  initial begin
    int n;
    run(3);
    // R9 reset state
    chk("R9 holdover", holdover, 1);
    chk("R9 activeSel", activeSel, 0);
    chk("R9 backupValid", backupValid, 0);
    chk("R9 alignReq", alignReq, 0);
    @(negedge clk); rstN = 1;
    run(40);
    chk("R8 idle holdover", holdover, 1);
    // R1: period 16 exceeds the timeout, never present
    halfA = 8; enA = 1; run(100);
    chk("R1 slow ref ignored", holdover, 1);
    enA = 0; halfA = 3; run(30);
    // R4: only B
    enB = 1; run(60);
    chk("R4 B active", activeSel, 1);
    chk("R4 left holdover", holdover, 0);
    chk("R3 no backup", backupValid, 0);
    // R6 non-revertive, R7 one align pulse
    alignCount = 0; enA = 1; run(60);
    chk("R6 stays on B", activeSel, 1);
    chk("R3 A as backup", backupValid, 1);
    chk("R7 single align pulse", alignCount, 1);
    // R6 failover to A
    enB = 0; run(60);
    chk("R6 failover to A", activeSel, 0);
    chk("R6 not holdover", holdover, 0);
    chk("R3 backup gone", backupValid, 0);
    alignCount = 0; enB = 1; run(60);
    chk("R6 A keeps role", activeSel, 0);
    chk("R7 recovered backup aligned", alignCount, 1);
    // R8 both lost
    enA = 0; enB = 0; run(60);
    chk("R8 holdover entered", holdover, 1);
    chk("R3 no backup in holdover", backupValid, 0);
    // R5 both at once from holdover
    alignCount = 0; enA = 1; enB = 1; run(60);
    chk("R5 A priority", activeSel, 0);
    chk("R5 left holdover", holdover, 0);
    chk("R5 B backup", backupValid, 1);
    chk("R7 align on entry", alignCount, 1);
    // R2 latency from holdover
    enA = 0; enB = 0; run(60);
    enB = 1; tick();
    n = 0;
    do begin tick(); n++; end while (holdover && n < 100);
    chk("R2 detect latency", n, 16);
    run(20);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule